// File: doc/BRIEF.md
# Clock-Synchronous Serial Channel

This block is one 8-bit clock-synchronous serial channel. A host writes a byte into a transmit holding register. When the channel is allowed to start, it moves that byte into a shift register and clocks it out on `txd`, one bit per transfer-clock cycle. In the same cycles it collects eight bits from `rxd` into a receive shift register. The finished byte is then moved into a receive holding register, which the host reads.

The transfer clock has two sources. The first is an internal divider running off one of four prescaled versions of the system clock; the block drives this clock out on `sclk_out`. The second is an external clock on `sclk_in`, which is synchronized to the system clock and edge-detected; it must run slower than a quarter of the system clock.

Configuration inputs set the following:
- clock polarity;
- bit order;
- data inversion;
- continuous receive;
- which event raises the transmit interrupt;
- flow control: off, clear-to-send input, or request-to-send output.

Reception is never independent of transmission: a byte arrives only while a byte (real or dummy) is being sent.

Top module: `csio_channel`

## Requirements
- R1: After reset, with all configuration inputs low, the outputs are as follows: `sclk_out`=1, `txd`=1, `tx_buf_empty`=1, `busy`=0, `rx_full`=0, `overrun`=0, `rts_n`=1, and both interrupt pulses are 0.
- R2: With the internal clock, one transfer-clock period lasts 2*(`cfg_div`+1)*P system clocks. P is 1, 2, 8 or 32 for `cfg_presc` codes 0, 1, 2 and 3. A frame lasts exactly 8 periods and leaves the clock at its idle level.
- R3: A frame starts only when all three of these hold: `cfg_tx_en`=1, the transmit holding register is full (`tx_buf_empty`=0), and, with `cfg_flow`=1 (clear-to-send), the synchronized `cts_n` is low. While `cts_n` is high, nothing is sent.
- R4: A byte is received only during a frame that started while `cfg_rx_en`=1. With receive enabled but no byte to send, nothing is received. A frame run with receive disabled leaves `rx_full` at 0 and raises no receive interrupt.
- R5: With `cfg_pol`=0, the clock idles high, `txd` changes on the falling edge and `rxd` is sampled on the rising edge. With `cfg_pol`=1, the clock idles low and both edges swap roles.
- R6: With `cfg_msb_first`=0, bit 0 is sent first and the first received bit lands in bit 0. With `cfg_msb_first`=1, bit 7 is sent first and the first received bit lands in bit 7.
- R7: With `cfg_invert`=1, `txd` carries the complement of each data bit, and each received line bit is complemented before it is stored.
- R8: With `cfg_txirq_done`=0, `tx_irq` pulses for one cycle together with the rise of `busy`, when the byte moves into the shift register. With `cfg_txirq_done`=1, it pulses once after the eighth sample edge instead.
- R9: When a frame's byte is stored, `rx_full` rises and `rx_irq` pulses for one cycle. A one-cycle `rb_rd` clears `rx_full`.
- R10: If `rx_full` is still set when the 7th bit of the next received frame is sampled, the following happens:
  - `overrun` sets and stays set until `cfg_rx_en` goes low;
  - no `rx_irq` is raised;
  - `rb_rdata` keeps its old value.
- R11: With `cfg_cont_rx`=1, an `rb_rd` marks the transmit holding register full again, so the same byte is sent in a new frame with no host write.
- R12: With `cfg_flow`=2 (request-to-send), `rts_n` is 0 while receive is enabled and the receive register is empty, and 1 while it is full. In every other flow mode, `rts_n` is 1.
- R13: With `cfg_ext_clk`=1, bits are shifted and sampled on edges of `sclk_in`. A frame does not start until `sclk_in` sits at the idle level for the selected polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_ext_clk | input | 1 | 1: transfer clock from `sclk_in` |
| cfg_presc | input | 2 | Prescaler select: /1, /2, /8, /32 |
| cfg_div | input | 8 | Divider setting n |
| cfg_pol | input | 1 | Clock polarity |
| cfg_msb_first | input | 1 | Bit order |
| cfg_invert | input | 1 | Invert line data |
| cfg_cont_rx | input | 1 | Continuous receive mode |
| cfg_txirq_done | input | 1 | Transmit interrupt on completion |
| cfg_flow | input | 2 | 0/3 off, 1 clear-to-send, 2 request-to-send |
| tb_wr | input | 1 | Write strobe for the transmit holding register |
| tb_wdata | input | 8 | Byte to send |
| rb_rd | input | 1 | Read strobe for the receive holding register |
| rb_rdata | output | 8 | Received byte |
| tx_buf_empty | output | 1 | Transmit holding register empty |
| busy | output | 1 | Frame in progress |
| rx_full | output | 1 | Receive holding register holds unread data |
| overrun | output | 1 | Overrun flag |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock out |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The bench acts as the peer device. It drives `rxd` on each shift edge and captures `txd` on each sample edge, so a swapped edge role shows up as a shifted or garbled byte. A wrong divider shows up as a transfer-clock period that differs from 2*(n+1)*P. The corner cases it targets each expose a specific fault:
- An overrun frame that a faulty design would store, or would announce with an interrupt.
- A transmit held back by a high `cts_n`, which a design that ignores flow control would send anyway.
- An external clock parked at the wrong level, from which a careless start would clock a stray bit.
- A continuous-mode read, which a design lacking that mode would leave idle.

// File: rtl/csio_pkg.sv
package csio_pkg;

  typedef enum logic [1:0] {
    FLOW_OFF = 2'd0,
    FLOW_CTS = 2'd1,
    FLOW_RTS = 2'd2,
    FLOW_NONE = 2'd3
  } flow_e;

  typedef enum logic [1:0] {
    PRE_DIV1  = 2'd0,
    PRE_DIV2  = 2'd1,
    PRE_DIV8  = 2'd2,
    PRE_DIV32 = 2'd3
  } presc_e;

  // Low bits of the free-running prescaler that must all be set for a tick.
  function automatic logic [31:0] presc_mask(presc_e sel);
    case (sel)
      PRE_DIV1:  return 32'd0;
      PRE_DIV2:  return 32'd1;
      PRE_DIV8:  return 32'd7;
      default:   return 32'd31;
    endcase
  endfunction

endpackage

// File: rtl/csio_clkgen.sv
module csio_clkgen
  import csio_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_sel,
  input  logic [1:0]       presc_sel,
  input  logic [DIV_W-1:0] div,
  input  logic             pol,
  input  logic             active,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             shift_ev,
  output logic             sample_ev,
  output logic             ext_idle
);

  localparam int SYNC_W = SYNC_STAGES + 1;

  logic [PRE_W-1:0]  pre_cnt;
  logic [PRE_W-1:0]  pre_mask;
  logic              pre_en;
  logic [DIV_W-1:0]  half_cnt;
  logic              sclk_q;
  logic              idle_lvl;
  logic [SYNC_W-1:0] sync_q;
  logic              ext_lvl;
  logic              ext_prev;
  logic              int_tog;
  logic              ext_tog;

  assign idle_lvl = ~pol;
  assign pre_mask = PRE_W'(presc_mask(presc_e'(presc_sel)));
  assign pre_en   = (pre_cnt & pre_mask) == pre_mask;

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + 1'b1;
  end

  // External clock: synchronizer chain plus one extra stage for edge detection.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_W-2:0], sclk_in};
  end

  assign ext_lvl  = sync_q[SYNC_STAGES-1];
  assign ext_prev = sync_q[SYNC_STAGES];
  assign ext_idle = (ext_lvl == idle_lvl) && (ext_prev == idle_lvl);

  // Internal clock: toggles every (div+1) prescaler ticks while a frame runs.
  always_ff @(posedge clk) begin
    if (rst) begin
      half_cnt <= '0;
      sclk_q   <= 1'b1;
    end else if (!active || ext_sel) begin
      half_cnt <= '0;
      sclk_q   <= idle_lvl;
    end else if (pre_en) begin
      if (half_cnt == div) begin
        half_cnt <= '0;
        sclk_q   <= ~sclk_q;
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  assign int_tog  = active && !ext_sel && pre_en && (half_cnt == div);
  assign ext_tog  = active && ext_sel && (ext_lvl != ext_prev);

  assign shift_ev  = (int_tog && (sclk_q == idle_lvl)) ||
                     (ext_tog && (ext_lvl != idle_lvl));
  assign sample_ev = (int_tog && (sclk_q != idle_lvl)) ||
                     (ext_tog && (ext_lvl == idle_lvl));
  assign sclk_out  = sclk_q;

  // R5
  sample_returns_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_ev && !ext_sel) |=> (sclk_q == $past(idle_lvl)));

endmodule

// File: rtl/csio_frame.sv
module csio_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              msb_first,
  input  logic              invert,
  input  logic              cont_rx,
  input  logic              tx_irq_sel,
  input  logic              cts_ok,
  input  logic              clk_ready,
  input  logic              tb_wr,
  input  logic [DATA_W-1:0] tb_wdata,
  input  logic              rb_rd,
  input  logic              shift_ev,
  input  logic              sample_ev,
  input  logic              rxd,
  output logic              busy,
  output logic              tb_full,
  output logic              txd,
  output logic              tx_irq,
  output logic              rx_part,
  output logic              seventh,
  output logic              frame_done,
  output logic [DATA_W-1:0] rx_word
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] SEVENTH_BIT = CNT_W'(DATA_W - 2);

  logic [DATA_W-1:0] tb_data;
  logic [DATA_W-1:0] tsr;
  logic [DATA_W-1:0] rsr;
  logic [CNT_W-1:0]  bitcnt;
  logic              start;
  logic              done_now;
  logic              sev_now;
  logic              out_bit;
  logic              in_bit;

  assign start    = !busy && tx_en && tb_full && cts_ok && clk_ready;
  assign done_now = busy && sample_ev && (bitcnt == LAST_BIT);
  assign sev_now  = busy && sample_ev && (bitcnt == SEVENTH_BIT);
  assign out_bit  = (msb_first ? tsr[DATA_W-1] : tsr[0]) ^ invert;
  assign in_bit   = rxd ^ invert;
  assign rx_word  = rsr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      tb_full    <= 1'b0;
      tb_data    <= '0;
      tsr        <= '0;
      rsr        <= '0;
      bitcnt     <= '0;
      txd        <= 1'b1;
      tx_irq     <= 1'b0;
      rx_part    <= 1'b0;
      seventh    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      tx_irq     <= tx_irq_sel ? done_now : start;
      seventh    <= sev_now;
      frame_done <= done_now;

      if (tb_wr) begin
        tb_data <= tb_wdata;
        tb_full <= 1'b1;
      end else if (start) begin
        tb_full <= 1'b0;
      end else if (rb_rd && cont_rx) begin
        tb_full <= 1'b1;
      end

      if (start) begin
        busy    <= 1'b1;
        tsr     <= tb_data;
        bitcnt  <= '0;
        rx_part <= rx_en;
      end else if (busy) begin
        if (shift_ev) begin
          txd <= out_bit;
          tsr <= msb_first ? {tsr[DATA_W-2:0], 1'b0} : {1'b0, tsr[DATA_W-1:1]};
        end
        if (sample_ev) begin
          rsr    <= msb_first ? {rsr[DATA_W-2:0], in_bit} : {in_bit, rsr[DATA_W-1:1]};
          bitcnt <= bitcnt + 1'b1;
          if (done_now) busy <= 1'b0;
        end
      end
    end
  end

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(tx_en) && $past(cts_ok)));

  // R8
  txirq_at_load_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_irq && !$past(tx_irq_sel)) |-> busy);

endmodule

// File: rtl/csio_rxbuf.sv
module csio_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              rts_mode,
  input  logic              rb_rd,
  input  logic              seventh,
  input  logic              frame_done,
  input  logic              rx_part,
  input  logic [DATA_W-1:0] rx_word,
  output logic [DATA_W-1:0] rb_data,
  output logic              rx_full,
  output logic              overrun,
  output logic              rx_irq,
  output logic              rts_n
);

  logic frame_ovr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_data   <= '0;
      rx_full   <= 1'b0;
      overrun   <= 1'b0;
      rx_irq    <= 1'b0;
      rts_n     <= 1'b1;
      frame_ovr <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      rts_n  <= !(rts_mode && rx_en && !rx_full);

      if (rb_rd) rx_full <= 1'b0;

      if (seventh && rx_part && rx_full) begin
        overrun   <= 1'b1;
        frame_ovr <= 1'b1;
      end

      if (frame_done && rx_part) begin
        if (frame_ovr) begin
          frame_ovr <= 1'b0;
        end else begin
          rb_data <= rx_word;
          rx_full <= 1'b1;
          rx_irq  <= 1'b1;
        end
      end

      if (!rx_en) overrun <= 1'b0;
    end
  end

  // R10
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_full));

  // R9
  irq_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);

endmodule

// File: rtl/csio_channel.sv
module csio_channel
  import csio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_en,
  input  logic              cfg_ext_clk,
  input  logic [1:0]        cfg_presc,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_pol,
  input  logic              cfg_msb_first,
  input  logic              cfg_invert,
  input  logic              cfg_cont_rx,
  input  logic              cfg_txirq_done,
  input  logic [1:0]        cfg_flow,
  input  logic              tb_wr,
  input  logic [DATA_W-1:0] tb_wdata,
  input  logic              rb_rd,
  output logic [DATA_W-1:0] rb_rdata,
  output logic              tx_buf_empty,
  output logic              busy,
  output logic              rx_full,
  output logic              overrun,
  output logic              tx_irq,
  output logic              rx_irq,
  input  logic              sclk_in,
  output logic              sclk_out,
  input  logic              cts_n,
  output logic              rts_n,
  output logic              txd,
  input  logic              rxd
);

  logic [SYNC_STAGES-1:0] cts_sync;
  logic                   cts_ok;
  logic                   clk_ready;
  logic                   ext_idle;
  logic                   shift_ev;
  logic                   sample_ev;
  logic                   tb_full;
  logic                   rx_part;
  logic                   seventh;
  logic                   frame_done;
  logic [DATA_W-1:0]      rx_word;
  logic                   rts_mode;

  always_ff @(posedge clk) begin
    if (rst) cts_sync <= '1;
    else     cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_n};
  end

  assign cts_ok       = (flow_e'(cfg_flow) != FLOW_CTS) || !cts_sync[SYNC_STAGES-1];
  assign rts_mode     = (flow_e'(cfg_flow) == FLOW_RTS);
  assign clk_ready    = !cfg_ext_clk || ext_idle;
  assign tx_buf_empty = !tb_full;

  csio_clkgen #(
    .DIV_W      (DIV_W),
    .PRE_W      (PRE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) clkgen_i (
    .clk      (clk),
    .rst      (rst),
    .ext_sel  (cfg_ext_clk),
    .presc_sel(cfg_presc),
    .div      (cfg_div),
    .pol      (cfg_pol),
    .active   (busy),
    .sclk_in  (sclk_in),
    .sclk_out (sclk_out),
    .shift_ev (shift_ev),
    .sample_ev(sample_ev),
    .ext_idle (ext_idle)
  );

  csio_frame #(
    .DATA_W(DATA_W)
  ) frame_i (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (cfg_tx_en),
    .rx_en     (cfg_rx_en),
    .msb_first (cfg_msb_first),
    .invert    (cfg_invert),
    .cont_rx   (cfg_cont_rx),
    .tx_irq_sel(cfg_txirq_done),
    .cts_ok    (cts_ok),
    .clk_ready (clk_ready),
    .tb_wr     (tb_wr),
    .tb_wdata  (tb_wdata),
    .rb_rd     (rb_rd),
    .shift_ev  (shift_ev),
    .sample_ev (sample_ev),
    .rxd       (rxd),
    .busy      (busy),
    .tb_full   (tb_full),
    .txd       (txd),
    .tx_irq    (tx_irq),
    .rx_part   (rx_part),
    .seventh   (seventh),
    .frame_done(frame_done),
    .rx_word   (rx_word)
  );

  csio_rxbuf #(
    .DATA_W(DATA_W)
  ) rxbuf_i (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (cfg_rx_en),
    .rts_mode  (rts_mode),
    .rb_rd     (rb_rd),
    .seventh   (seventh),
    .frame_done(frame_done),
    .rx_part   (rx_part),
    .rx_word   (rx_word),
    .rb_data   (rb_rdata),
    .rx_full   (rx_full),
    .overrun   (overrun),
    .rx_irq    (rx_irq),
    .rts_n     (rts_n)
  );

endmodule

// File: tb/csio_channel_tb_top.sv
module csio_channel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  // Vector fields: [28] pol [27] msb [26] inv [25:24] presc [23:16] div [15:8] tx byte [7:0] peer line bits
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 8'h5A, 8'h3C},
    {1'b1, 1'b0, 1'b0, 2'd0, 8'd2, 8'hC3, 8'h96},
    {1'b0, 1'b1, 1'b0, 2'd1, 8'd1, 8'h81, 8'h0F},
    {1'b0, 1'b0, 1'b1, 2'd2, 8'd0, 8'h27, 8'hE1},
    {1'b1, 1'b1, 1'b1, 2'd0, 8'd4, 8'hF0, 8'h55},
    {1'b0, 1'b0, 1'b0, 2'd3, 8'd0, 8'h01, 8'hFE}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_tx_en = 0, cfg_rx_en = 0, cfg_ext_clk = 0;
  logic [1:0] cfg_presc = 0;
  logic [7:0] cfg_div = 0;
  logic       cfg_pol = 0, cfg_msb_first = 0, cfg_invert = 0, cfg_cont_rx = 0, cfg_txirq_done = 0;
  logic [1:0] cfg_flow = 0;
  logic       tb_wr = 0;
  logic [7:0] tb_wdata = 0;
  logic       rb_rd = 0;
  logic [7:0] rb_rdata;
  logic       tx_buf_empty, busy, rx_full, overrun, tx_irq, rx_irq;
  logic       bench_sclk = 1'b1;
  logic       sclk_out;
  logic       cts_n = 1'b1;
  logic       rts_n, txd;
  logic       rxd = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int txirq_cnt = 0;
  int rxirq_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (tx_irq === 1'b1) txirq_cnt++;
    if (rx_irq === 1'b1) rxirq_cnt++;
  end

  csio_channel dut_i (
    .clk(clk), .rst(rst), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
    .cfg_ext_clk(cfg_ext_clk), .cfg_presc(cfg_presc), .cfg_div(cfg_div),
    .cfg_pol(cfg_pol), .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
    .cfg_cont_rx(cfg_cont_rx), .cfg_txirq_done(cfg_txirq_done), .cfg_flow(cfg_flow),
    .tb_wr(tb_wr), .tb_wdata(tb_wdata), .rb_rd(rb_rd), .rb_rdata(rb_rdata),
    .tx_buf_empty(tx_buf_empty), .busy(busy), .rx_full(rx_full), .overrun(overrun),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .sclk_in(bench_sclk), .sclk_out(sclk_out),
    .cts_n(cts_n), .rts_n(rts_n), .txd(txd), .rxd(rxd)
  );

  // Peer device: drives rxd on leaving-idle edges, captures txd on returning edges.
  logic       peer_on = 1'b0;
  logic       peer_pol = 1'b0;
  logic [7:0] peer_line = 8'h00;
  logic [7:0] cap = 8'h00;
  int         pcnt = 0;
  int         edge_cyc0 = 0;
  int         edge_cyc1 = 0;
  wire        sclk_line = cfg_ext_clk ? bench_sclk : sclk_out;

  always @(sclk_line) begin
    if (peer_on && !$isunknown(sclk_line)) begin
      if (sclk_line == peer_pol) begin
        if (pcnt < 8) begin
          rxd = peer_line[pcnt];
          if (pcnt == 0) edge_cyc0 = cyc;
          if (pcnt == 1) edge_cyc1 = cyc;
        end
      end else if (pcnt < 8) begin
        cap[pcnt] = txd;
        pcnt++;
      end
    end
  end

  function automatic logic [7:0] tx_line(logic [7:0] d, logic msb, logic inv);
    logic [7:0] l;
    for (int k = 0; k < 8; k++) l[k] = (msb ? d[7-k] : d[k]) ^ inv;
    return l;
  endfunction

  function automatic logic [7:0] rx_exp(logic [7:0] line, logic msb, logic inv);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      if (msb) r[7-k] = line[k] ^ inv;
      else     r[k]   = line[k] ^ inv;
    end
    return r;
  endfunction

  function automatic int period_exp(logic [1:0] presc, logic [7:0] div);
    int p;
    case (presc)
      2'd0: p = 1;
      2'd1: p = 2;
      2'd2: p = 8;
      default: p = 32;
    endcase
    return 2 * (int'(div) + 1) * p;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_busy(input string tag);
    int n = 0;
    while (busy !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(busy === 1'b1, tag, busy, 1);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy !== 1'b0 && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk(busy === 1'b0, tag, busy, 0);
  endtask

  task automatic arm_peer(input logic [7:0] line);
    peer_pol  = cfg_pol;
    peer_line = line;
    cap       = 8'h00;
    pcnt      = 0;
  endtask

  task automatic write_tb(input logic [7:0] d);
    tb_wdata = d;
    tb_wr    = 1'b1;
    @(negedge clk);
    tb_wr    = 1'b0;
  endtask

  task automatic read_rb();
    rb_rd = 1'b1;
    @(negedge clk);
    rb_rd = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [7:0] line, input string tag);
    arm_peer(line);
    write_tb(d);
    wait_busy(tag);
    wait_idle(tag);
    cycles(3);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int irq0;
    int rirq0;
    logic [7:0] old_rb;

    rst = 1'b1;
    cycles(5);
    rst = 1'b0;
    cycles(2);
    // R1 reset state
    chk(sclk_out === 1'b1, "R1 sclk_out", sclk_out, 1);
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(tx_buf_empty === 1'b1 && busy === 1'b0, "R1 buffer/busy",
        {tx_buf_empty, busy}, 2'b10);
    chk(rx_full === 1'b0 && overrun === 1'b0 && rts_n === 1'b1, "R1 rx flags",
        {rx_full, overrun, rts_n}, 3'b001);
    chk(tx_irq === 1'b0 && rx_irq === 1'b0, "R1 irqs", {tx_irq, rx_irq}, 0);

    peer_on   = 1'b1;
    cfg_tx_en = 1'b1;
    cfg_rx_en = 1'b1;

    // Table-driven frames: R2 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      cfg_pol       = VEC[v][28];
      cfg_msb_first = VEC[v][27];
      cfg_invert    = VEC[v][26];
      cfg_presc     = VEC[v][25:24];
      cfg_div       = VEC[v][23:16];
      cycles(4);
      irq0 = txirq_cnt;
      run_frame(VEC[v][15:8], VEC[v][7:0], "R5 R6 R7 frame");
      chk(cap === tx_line(VEC[v][15:8], VEC[v][27], VEC[v][26]), "R5 R6 R7 txd bits",
          cap, tx_line(VEC[v][15:8], VEC[v][27], VEC[v][26]));
      chk(rb_rdata === rx_exp(VEC[v][7:0], VEC[v][27], VEC[v][26]), "R6 R7 R9 received byte",
          rb_rdata, rx_exp(VEC[v][7:0], VEC[v][27], VEC[v][26]));
      chk(edge_cyc1 - edge_cyc0 == period_exp(VEC[v][25:24], VEC[v][23:16]), "R2 clock period",
          edge_cyc1 - edge_cyc0, period_exp(VEC[v][25:24], VEC[v][23:16]));
      chk(sclk_out === ~VEC[v][28], "R2 R5 idle level", sclk_out, ~VEC[v][28]);
      chk(rx_full === 1'b1, "R9 rx_full set", rx_full, 1);
      chk(txirq_cnt == irq0 + 1, "R8 one tx irq", txirq_cnt, irq0 + 1);
      read_rb();
      cycles(1);
      chk(rx_full === 1'b0, "R9 read clears", rx_full, 0);
    end

    cfg_pol = 0; cfg_msb_first = 0; cfg_invert = 0; cfg_presc = 0; cfg_div = 1;
    cycles(4);

    // R8 completion timing
    cfg_txirq_done = 1'b1;
    irq0 = txirq_cnt;
    arm_peer(8'h00);
    write_tb(8'h33);
    wait_busy("R8 busy");
    cycles(3);
    chk(txirq_cnt == irq0, "R8 no irq at load", txirq_cnt, irq0);
    wait_idle("R8 idle");
    cycles(3);
    chk(txirq_cnt == irq0 + 1, "R8 irq at completion", txirq_cnt, irq0 + 1);
    cfg_txirq_done = 1'b0;
    read_rb();

    // R3 clear-to-send hold-off
    cfg_flow = 2'd1;
    cts_n = 1'b1;
    arm_peer(8'h00);
    write_tb(8'h42);
    cycles(40);
    chk(busy === 1'b0 && tx_buf_empty === 1'b0, "R3 held by cts_n",
        {busy, tx_buf_empty}, 2'b00);
    cts_n = 1'b0;
    wait_busy("R3 starts on cts low");
    wait_idle("R3 idle");
    cycles(3);
    chk(cap === 8'h42, "R3 byte sent", cap, 8'h42);
    cts_n = 1'b1;
    cfg_flow = 2'd0;
    read_rb();

    // R4 nothing to send: no reception
    cycles(40);
    chk(rx_full === 1'b0 && busy === 1'b0, "R4 no frame without data", {rx_full, busy}, 0);
    // R3 transmit disabled
    cfg_tx_en = 1'b0;
    write_tb(8'h11);
    cycles(40);
    chk(busy === 1'b0, "R3 tx disabled", busy, 0);
    // R4 receive disabled frame
    cfg_rx_en = 1'b0;
    rirq0 = rxirq_cnt;
    arm_peer(8'hA0);
    cfg_tx_en = 1'b1;
    wait_busy("R4 busy");
    wait_idle("R4 idle");
    cycles(3);
    chk(rx_full === 1'b0 && rxirq_cnt == rirq0, "R4 nothing stored", rx_full, 0);
    cfg_rx_en = 1'b1;

    // R12 request-to-send
    cfg_flow = 2'd2;
    cycles(3);
    chk(rts_n === 1'b0, "R12 ready", rts_n, 0);
    run_frame(8'h99, 8'h66, "R12 frame");
    chk(rts_n === 1'b1, "R12 full", rts_n, 1);
    read_rb();
    cycles(3);
    chk(rts_n === 1'b0, "R12 ready again", rts_n, 0);
    cfg_flow = 2'd0;
    cycles(3);
    chk(rts_n === 1'b1, "R12 other mode high", rts_n, 1);

    // R10 overrun
    rirq0 = rxirq_cnt;
    run_frame(8'h12, 8'h11, "R10 first");
    old_rb = rb_rdata;
    chk(old_rb === 8'h11 && rxirq_cnt == rirq0 + 1, "R10 first stored", old_rb, 8'h11);
    run_frame(8'h34, 8'hEE, "R10 second");
    chk(overrun === 1'b1, "R10 overrun set", overrun, 1);
    chk(rxirq_cnt == rirq0 + 1, "R10 no irq", rxirq_cnt, rirq0 + 1);
    chk(rb_rdata === old_rb, "R10 buffer kept", rb_rdata, old_rb);
    read_rb();
    cycles(2);
    chk(overrun === 1'b1, "R10 sticky after read", overrun, 1);
    cfg_rx_en = 1'b0;
    cycles(3);
    chk(overrun === 1'b0, "R10 cleared by rx disable", overrun, 0);
    cfg_rx_en = 1'b1;

    // R11 continuous receive
    cfg_cont_rx = 1'b1;
    run_frame(8'hA5, 8'h33, "R11 first");
    chk(rx_full === 1'b1, "R11 first stored", rx_full, 1);
    arm_peer(8'h0C);
    read_rb();
    wait_busy("R11 restart on read");
    wait_idle("R11 idle");
    cycles(3);
    chk(cap === 8'hA5, "R11 same byte resent", cap, 8'hA5);
    chk(rb_rdata === 8'h0C, "R11 second received", rb_rdata, 8'h0C);
    cfg_cont_rx = 1'b0;
    read_rb();

    // R13 external clock
    bench_sclk = 1'b1;
    cfg_ext_clk = 1'b1;
    cycles(4);
    bench_sclk = 1'b0;
    cycles(2);
    write_tb(8'hC6);
    cycles(20);
    chk(busy === 1'b0, "R13 waits for idle clock", busy, 0);
    bench_sclk = 1'b1;
    @(negedge clk);
    arm_peer(8'h9A);
    wait_busy("R13 start");
    for (int b = 0; b < 8; b++) begin
      cycles(10);
      bench_sclk = 1'b0;
      cycles(10);
      bench_sclk = 1'b1;
    end
    wait_idle("R13 idle");
    cycles(3);
    chk(cap === 8'hC6, "R13 txd bits", cap, 8'hC6);
    chk(rb_rdata === 8'h9A, "R13 received byte", rb_rdata, 8'h9A);
    cfg_ext_clk = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule